// File: doc/BRIEF.md
# Dual-Mode Serial Conversion-Result Port

This block is the device-side digital output of a read-only converter. It has no command input. An upstream stage delivers a periodic one-cycle strobe with a 24-bit result word. The port holds that word and sends it out most significant bit first on a single pin. That pin also acts as the data-ready flag: it is pulled low when a result is waiting and returns high once the word has been read. The word is passed through unchanged. Offset-binary coding is therefore kept: all zeros is negative full scale, 0x800000 is zero and all ones is positive full scale.

A strap input picks who clocks the transfer. In master mode the port drives the serial clock itself and produces exactly one word's worth of clock periods, each one base-clock period long. In slave mode an external clock is accepted. That clock may arrive in bursts with pauses, and the bit position is kept across the pauses. Chip select powers the port up and down. While chip select is deselected the port discards everything and releases both of its outputs. After selection, results are taken only once a settling time of two conversion periods has passed.

If the held result is not read, the ready flag is withdrawn a guard interval before the next update is due, so that no read starts while the word is being replaced. In slave mode, a strobe that arrives while a read is in progress is dropped.

Top module: `ofs_port`

## Requirements
- R1: After reset, and whenever chip select is deselected, `dout_oe` and `sclk_oe` are 0, `dout_rdy` is 1 and `sclk_out` is 1.
- R2: Result strobes are ignored until `2*CONV_BASE*2*BASE_HALF` clock cycles after the synchronised chip select becomes active. An ignored strobe leaves `dout_rdy` high.
- R3: An accepted strobe pulls `dout_rdy` low one cycle later. It stays low until the transfer starts or the word is withdrawn.
- R4: Bit k of the stream (k=0 first) is `res_word[23-k]`. Each bit is presented after a serial clock falling edge and holds through the following rising edge. The word is sent unmodified, so 0x000000, 0x800000 and 0xFFFFFF come out as given.
- R5: In master mode (`mode_pin`=0 sampled) `sclk_oe` is 1 while the port is selected. For each result `sclk_out` makes exactly 24 rising edges spaced `2*BASE_HALF` clock cycles apart. The first falling edge comes no earlier than `BASE_HALF` cycles after `dout_rdy` falls, and the clock idles high afterwards.
- R6: After the last bit, `dout_rdy` returns high. In master mode this happens `BASE_HALF` cycles after the 24th rising edge. In slave mode it happens on detection of the 24th external rising edge.
- R7: In slave mode (`mode_pin`=1 sampled) `sclk_oe` is 0 and the port never drives `sclk_out` low. The word is read with the external clock either in one burst or in groups with pauses, and the bit position is kept across the pauses.
- R8: A waiting result that is not read is withdrawn. `dout_rdy` goes high `CONV_BASE*2*BASE_HALF - GUARD_BASE*2*BASE_HALF` cycles after the load, before the next update is due.
- R9: A strobe that arrives while a slave read is in progress is dropped. The word being read is not corrupted, and `dout_rdy` stays high after that read.
- R10: Deselecting chip select aborts any transfer and discards the held word. After reselection `dout_rdy` stays high until a new result is accepted, and the next read starts again at bit 23.
- R11: `mode_pin` is sampled only while chip select is deselected. Changing it while selected has no effect on `sclk_oe`, `sclk_out` or the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock; one base-clock period is 2*BASE_HALF cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| mode_pin | input | 1 | Strap: 0 master, 1 slave |
| sclk_in | input | 1 | External serial clock (slave mode), asynchronous |
| res_valid | input | 1 | One-cycle result strobe from upstream |
| res_word | input | 24 | Result word, offset binary |
| sclk_out | output | 1 | Driven serial clock value (master mode) |
| sclk_oe | output | 1 | Output enable for the serial clock pin |
| dout_rdy | output | 1 | Shared data-ready flag / serial data |
| dout_oe | output | 1 | Output enable for the data/ready pin |

## Verification
The bench builds the port with `CONV_BASE`=40, `BASE_HALF`=2 and `GUARD_BASE`=2. With these values a conversion period is 160 clock cycles, settling takes 320 cycles and the withdraw point falls at cycle 152 after a load. Settling, withdrawal and repeated reselection therefore all occur within a few hundred cycles. A base half period of two cycles still leaves the master clock with distinct low and high phases, so the bench can measure edge spacing and the delay from the ready flag to the first edge. The slave clock runs at eight cycles per half period, so it stays well clear of the two-flop synchroniser delay.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  typedef enum logic [1:0] {
    SH_EMPTY = 2'd0,
    SH_ARMED = 2'd1,
    SH_SHIFT = 2'd2,
    SH_TAIL  = 2'd3
  } sh_state_t;

  // clock cycles in one conversion period
  function automatic int conv_clk_cycles(input int base_cycles, input int half_clks);
    return base_cycles * 2 * half_clks;
  endfunction

  // phase (cycles after a load) at which an unread word is withdrawn
  function automatic int withdraw_point(input int conv_clks, input int guard_base,
                                        input int half_clks);
    return conv_clks - guard_base * 2 * half_clks;
  endfunction

endpackage

// File: rtl/ofs_sync.sv
module ofs_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta  <= RST_VAL;
      q_out <= RST_VAL;
    end else begin
      meta  <= d_in;
      q_out <= meta;
    end
  end
endmodule

// File: rtl/ofs_frame.sv
module ofs_frame #(
  parameter int CONV_CYC    = 6624,
  parameter int SETTLE_CYC  = 13248,
  parameter int WITHDRAW_AT = 6616
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic res_valid,
  input  logic busy,
  output logic load,
  output logic stale,
  output logic settled
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam int PW = $clog2(CONV_CYC + 1);
  localparam logic [SW-1:0] SETTLE_V = SW'(SETTLE_CYC);
  localparam logic [PW-1:0] CONV_V   = PW'(CONV_CYC);
  localparam logic [PW-1:0] WD_V     = PW'(WITHDRAW_AT);

  logic [SW-1:0] since_sel;
  logic [PW-1:0] phase;

  assign settled = (since_sel == SETTLE_V);
  assign load    = sel & settled & res_valid & ~busy;
  assign stale   = sel & (phase == WD_V);

  // settle counter: cycles since chip select became active, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_sel <= '0;
    else if (!sel)            since_sel <= '0;
    else if (!settled)        since_sel <= since_sel + 1'b1;
  end

  // phase within the conversion period, restarted by each accepted load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               phase <= '0;
    else if (!sel || load)    phase <= '0;
    else if (phase != CONV_V) phase <= phase + 1'b1;
  end

  // R9
  drop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && busy) |-> !load);
endmodule

// File: rtl/ofs_shift.sv
module ofs_shift
  import ofs_pkg::*;
#(
  parameter int WORD_W    = 24,
  parameter int BASE_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              mode_slave,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              stale,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  output logic              dout,
  output logic              sclk_drv,
  output logic              busy,
  output logic              armed
);
  localparam int HW = $clog2(BASE_HALF + 1);
  localparam int CW = $clog2(WORD_W + 1);
  localparam logic [HW-1:0] HALF_M1 = HW'(BASE_HALF - 1);
  localparam logic [CW-1:0] LAST_V  = CW'(WORD_W - 1);

  sh_state_t          state;
  logic [WORD_W-1:0]  shreg;
  logic [CW-1:0]      cnt;
  logic [HW-1:0]      hcnt;
  logic               half_done;

  assign busy      = (state == SH_SHIFT) || (state == SH_TAIL);
  assign armed     = (state == SH_ARMED);
  assign half_done = (hcnt == HALF_M1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SH_EMPTY; shreg <= '0; cnt <= '0; hcnt <= '0;
      dout <= 1'b1; sclk_drv <= 1'b1;
    end else if (!sel) begin
      state <= SH_EMPTY; cnt <= '0; hcnt <= '0;
      dout <= 1'b1; sclk_drv <= 1'b1;
    end else if (load) begin
      state <= SH_ARMED; shreg <= word; cnt <= '0; hcnt <= '0;
      dout <= 1'b0; sclk_drv <= 1'b1;
    end else begin
      case (state)
        SH_ARMED: begin
          if (stale) begin
            state <= SH_EMPTY; dout <= 1'b1;
          end else if (mode_slave) begin
            if (sclk_fall) begin
              dout <= shreg[WORD_W-1]; shreg <= {shreg[WORD_W-2:0], 1'b0};
              state <= SH_SHIFT;
            end
          end else if (half_done) begin
            hcnt <= '0; sclk_drv <= 1'b0;
            dout <= shreg[WORD_W-1]; shreg <= {shreg[WORD_W-2:0], 1'b0};
            state <= SH_SHIFT;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        SH_SHIFT: begin
          if (mode_slave) begin
            if (sclk_fall) begin
              dout <= shreg[WORD_W-1]; shreg <= {shreg[WORD_W-2:0], 1'b0};
            end else if (sclk_rise) begin
              if (cnt == LAST_V) begin
                cnt <= '0; dout <= 1'b1; state <= SH_EMPTY;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end else if (half_done) begin
            hcnt <= '0;
            if (!sclk_drv) begin
              sclk_drv <= 1'b1;
              if (cnt == LAST_V) begin
                cnt <= '0; state <= SH_TAIL;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end else begin
              sclk_drv <= 1'b0;
              dout <= shreg[WORD_W-1]; shreg <= {shreg[WORD_W-2:0], 1'b0};
            end
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        SH_TAIL: begin
          if (half_done) begin
            hcnt <= '0; dout <= 1'b1; state <= SH_EMPTY;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R7
  slave_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_slave |-> sclk_drv);
  // R10
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (dout && !busy));
  // R9
  no_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
  // R8
  withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stale && armed && !load) |=> dout);
  // R5
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_V);
endmodule

// File: rtl/ofs_port.sv
module ofs_port #(
  parameter int WORD_W     = 24,
  parameter int BASE_HALF  = 2,
  parameter int CONV_BASE  = 1656,
  parameter int GUARD_BASE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              mode_pin,
  input  logic              sclk_in,
  input  logic              res_valid,
  input  logic [WORD_W-1:0] res_word,
  output logic              sclk_out,
  output logic              sclk_oe,
  output logic              dout_rdy,
  output logic              dout_oe
);
  localparam int CONV_CYC    = ofs_pkg::conv_clk_cycles(CONV_BASE, BASE_HALF);
  localparam int SETTLE_CYC  = 2 * CONV_CYC;
  localparam int WITHDRAW_AT = ofs_pkg::withdraw_point(CONV_CYC, GUARD_BASE, BASE_HALF);

  logic [1:0] sync_q;
  logic       sel, sclk_s, sclk_prev, sclk_rise, sclk_fall;
  logic       mode_q, load, stale, settled, busy, armed, dout_q, sclk_drv;

  ofs_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in({cs_n, sclk_in}), .q_out(sync_q)
  );

  assign sel       = ~sync_q[1];
  assign sclk_s    = sync_q[0];
  assign sclk_rise = sclk_s & ~sclk_prev;
  assign sclk_fall = ~sclk_s & sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b1;
      mode_q    <= 1'b0;
    end else begin
      sclk_prev <= sclk_s;
      if (!sel) mode_q <= mode_pin;
    end
  end

  ofs_frame #(
    .CONV_CYC(CONV_CYC), .SETTLE_CYC(SETTLE_CYC), .WITHDRAW_AT(WITHDRAW_AT)
  ) u_frame (
    .clk(clk), .rst_n(rst_n), .sel(sel), .res_valid(res_valid), .busy(busy),
    .load(load), .stale(stale), .settled(settled)
  );

  ofs_shift #(.WORD_W(WORD_W), .BASE_HALF(BASE_HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .sel(sel), .mode_slave(mode_q), .load(load),
    .word(res_word), .stale(stale), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .dout(dout_q), .sclk_drv(sclk_drv), .busy(busy), .armed(armed)
  );

  assign dout_rdy = dout_q;
  assign dout_oe  = sel;
  assign sclk_out = sclk_drv;
  assign sclk_oe  = sel & ~mode_q;

  // R2
  settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && $fell(dout_q)) |-> settled);
  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel) && sel) |-> $stable(mode_q));
endmodule

// File: tb/ofs_port_tb.sv
module ofs_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BH = 2;
  localparam int CB = 40;
  localparam int GB = 2;
  localparam int CONV = CB * 2 * BH;
  localparam int SETTLE = 2 * CONV;
  localparam int WDRAW = CONV - GB * 2 * BH;
  localparam int SHALF = 8;

  logic clk = 1'b0;
  logic rst_n, cs_n, mode_pin, sclk_in, res_valid;
  logic [23:0] res_word;
  logic sclk_out, sclk_oe, dout_rdy, dout_oe;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ofs_port #(.WORD_W(24), .BASE_HALF(BH), .CONV_BASE(CB), .GUARD_BASE(GB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .mode_pin(mode_pin), .sclk_in(sclk_in),
    .res_valid(res_valid), .res_word(res_word), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .dout_rdy(dout_rdy), .dout_oe(dout_oe)
  );

  task automatic expect_eq(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic select(input logic m);
    @(negedge clk); cs_n = 1'b1; mode_pin = m; sclk_in = 1'b1;
    wait_clk(6);
    cs_n = 1'b0;
    wait_clk(6);
  endtask

  task automatic strobe(input logic [23:0] w);
    @(negedge clk); res_valid = 1'b1; res_word = w;
    @(negedge clk); res_valid = 1'b0;
  endtask

  task automatic slave_bits(input int n, inout logic [23:0] got);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sclk_in = 1'b0;
      wait_clk(SHALF);
      got = {got[22:0], dout_rdy};
      sclk_in = 1'b1;
      wait_clk(SHALF);
    end
  endtask

  task automatic run_master(input logic [23:0] exp, input string tag);
    logic [23:0] got = '0;
    int nrise = 0;
    int t_low = -1;
    int t_fall = -1;
    int last_rise = -1;
    int bad_space = 0;
    logic prev_s = 1'b1;
    for (int c = 0; c < 400; c++) begin
      if (t_low < 0 && dout_rdy == 1'b0) t_low = c;
      if (t_fall < 0 && sclk_out == 1'b0) t_fall = c;
      if (!prev_s && sclk_out) begin
        got = {got[22:0], dout_rdy};
        if (last_rise >= 0 && (c - last_rise) != 2 * BH) bad_space++;
        last_rise = c;
        nrise++;
      end
      prev_s = sclk_out;
      @(negedge clk);
    end
    expect_eq("R3", {tag, " ready low right after load"}, t_low, 0);
    expect_eq("R5", {tag, " first fall not before half period"}, (t_fall - t_low >= BH), 1);
    expect_eq("R5", {tag, " rising edge count"}, nrise, 24);
    expect_eq("R5", {tag, " rising edge spacing errors"}, bad_space, 0);
    expect_eq("R4", {tag, " word MSB first"}, got, exp);
    expect_eq("R6", {tag, " ready high after word"}, dout_rdy, 1'b1);
    expect_eq("R5", {tag, " clock idles high"}, sclk_out, 1'b1);
  endtask

  task automatic t_reset;
    expect_eq("R1", "dout_oe after reset", dout_oe, 1'b0);
    expect_eq("R1", "sclk_oe after reset", sclk_oe, 1'b0);
    expect_eq("R1", "dout_rdy after reset", dout_rdy, 1'b1);
    expect_eq("R1", "sclk_out after reset", sclk_out, 1'b1);
  endtask

  task automatic t_master;
    select(1'b0);
    expect_eq("R5", "sclk_oe in master mode", sclk_oe, 1'b1);
    expect_eq("R1", "dout_oe when selected", dout_oe, 1'b1);
    strobe(24'h13579B);
    wait_clk(30);
    expect_eq("R2", "strobe before settle ignored", dout_rdy, 1'b1);
    expect_eq("R2", "no clock before settle", sclk_out, 1'b1);
    wait_clk(SETTLE);
    strobe(24'hA5C31E);
    run_master(24'hA5C31E, "master A");
  endtask

  task automatic t_codes;
    strobe(24'h800000); run_master(24'h800000, "R4 zero code");
    strobe(24'hFFFFFF); run_master(24'hFFFFFF, "R4 plus full");
    strobe(24'h000000); run_master(24'h000000, "R4 minus full");
  endtask

  task automatic t_slave_burst;
    logic [23:0] got = '0;
    select(1'b1);
    expect_eq("R7", "sclk_oe in slave mode", sclk_oe, 1'b0);
    wait_clk(SETTLE + 5);
    strobe(24'h3C5A96);
    wait_clk(5);
    expect_eq("R3", "slave ready low", dout_rdy, 1'b0);
    slave_bits(24, got);
    expect_eq("R7", "slave burst word", got, 24'h3C5A96);
    expect_eq("R7", "slave never drives clock low", sclk_out, 1'b1);
    wait_clk(8);
    expect_eq("R6", "slave ready high after 24 bits", dout_rdy, 1'b1);
  endtask

  task automatic t_slave_groups;
    logic [23:0] got = '0;
    strobe(24'h123456);
    wait_clk(5);
    slave_bits(8, got); wait_clk(60);
    slave_bits(8, got); wait_clk(60);
    slave_bits(8, got);
    expect_eq("R7", "slave grouped word", got, 24'h123456);
    wait_clk(8);
    expect_eq("R6", "ready high after grouped read", dout_rdy, 1'b1);
  endtask

  task automatic t_withdraw;
    strobe(24'h00FF00);
    wait_clk(20);
    expect_eq("R8", "ready low early in period", dout_rdy, 1'b0);
    wait_clk(WDRAW - 30);
    expect_eq("R8", "ready low before withdraw", dout_rdy, 1'b0);
    wait_clk(20);
    expect_eq("R8", "ready high after withdraw", dout_rdy, 1'b1);
  endtask

  task automatic t_drop;
    logic [23:0] got = '0;
    strobe(24'hC0FFEE);
    wait_clk(5);
    slave_bits(12, got);
    strobe(24'h111111);
    slave_bits(12, got);
    expect_eq("R9", "word intact after mid-read strobe", got, 24'hC0FFEE);
    wait_clk(8);
    expect_eq("R9", "dropped strobe leaves ready high", dout_rdy, 1'b1);
    wait_clk(40);
    expect_eq("R9", "ready still high later", dout_rdy, 1'b1);
  endtask

  task automatic t_abort;
    logic [23:0] got = '0;
    strobe(24'h5A5A5A);
    wait_clk(5);
    slave_bits(5, got);
    @(negedge clk); cs_n = 1'b1;
    wait_clk(6);
    expect_eq("R10", "dout_oe released", dout_oe, 1'b0);
    expect_eq("R10", "sclk_oe released", sclk_oe, 1'b0);
    expect_eq("R10", "ready high when deselected", dout_rdy, 1'b1);
    cs_n = 1'b0;
    wait_clk(6);
    expect_eq("R10", "old word gone after reselect", dout_rdy, 1'b1);
    strobe(24'h777777);
    wait_clk(10);
    expect_eq("R2", "unsettled strobe ignored", dout_rdy, 1'b1);
    wait_clk(SETTLE + 10);
    expect_eq("R10", "still no word before new load", dout_rdy, 1'b1);
    strobe(24'h654321);
    wait_clk(5);
    got = '0;
    slave_bits(24, got);
    expect_eq("R10", "read restarts at MSB", got, 24'h654321);
  endtask

  task automatic t_mode_hold;
    logic [23:0] got = '0;
    int falls = 0;
    @(negedge clk); mode_pin = 1'b0;
    wait_clk(5);
    expect_eq("R11", "sclk_oe unchanged by mode while selected", sclk_oe, 1'b0);
    strobe(24'h0F0F0F);
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (sclk_out == 1'b0) falls++;
    end
    expect_eq("R11", "no master clock after mode change", falls, 0);
    expect_eq("R11", "word still waiting", dout_rdy, 1'b0);
    slave_bits(24, got);
    expect_eq("R11", "slave read still works", got, 24'h0F0F0F);
    select(1'b0);
    expect_eq("R11", "mode taken while deselected", sclk_oe, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; mode_pin = 1'b0; sclk_in = 1'b1;
    res_valid = 1'b0; res_word = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_master();
    t_codes();
    t_slave_burst();
    t_slave_groups();
    t_withdraw();
    t_drop();
    t_abort();
    t_mode_hold();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule